// File: doc/BRIEF.md
# Fixed-Window Kernel Segment Address Decoder

This block takes a virtual address from a processor load/store or fetch port and sorts it into one of four segments using its top three bits. Two kernel segments bypass translation entirely. For these, the block forms the bus address by clearing the three segment-select bits and zero-extending the rest to the system bus width. One of these two windows is tagged cacheable and the other uncached. The other two segments, the low half of the space and the top quarter, need a translation lookaside buffer. For them the block raises a translation request and passes the virtual address through unchanged, so that an external translator can use it.

The block also polices privilege and translator state. In user mode, an access with the top address bit set becomes an address error instead of a bus request. An access to a mapped segment while the translator reports that it is not ready also becomes an address error. Every decision is combinational and sits in front of a single output register, so each result appears exactly one clock after the request that caused it.

Top module: `seg_addr_decode`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `o_valid`, `o_addr_err`, `o_need_mmu`, `o_cached` and `o_paddr` are all zero.
- R2: A request whose top three address bits are 100, with no error condition, gives `o_valid`=1, `o_cached`=1 and `o_need_mmu`=0. `o_paddr` is the address with its top three bits cleared, zero-extended to the bus width.
- R3: A request whose top three address bits are 101, with no error condition, gives `o_valid`=1, `o_cached`=0 and `o_need_mmu`=0. `o_paddr` is formed by the same three-bit clear and zero-extension as in R2.
- R4: A request with top address bit 0, with `i_xlat_ready`=1, gives `o_valid`=1, `o_need_mmu`=1 and `o_cached`=0. `o_paddr` carries the virtual address zero-extended. This holds in either privilege mode.
- R5: A kernel-mode request whose top two address bits are 11, with `i_xlat_ready`=1, gives `o_valid`=1, `o_need_mmu`=1 and `o_cached`=0. `o_paddr` carries the virtual address zero-extended.
- R6: A request with `i_user`=1 and top address bit 1 gives `o_addr_err`=1 with `o_valid`, `o_need_mmu`, `o_cached` and `o_paddr` all zero. The value of `i_xlat_ready` does not change this.
- R7: A request to a mapped segment (top bit 0, or top two bits 11) with `i_xlat_ready`=0 gives `o_addr_err`=1 with all other outputs zero.
- R8: Each result appears in the cycle directly after its request cycle, and requests may arrive back to back. A cycle with `i_valid`=0 produces all-zero outputs in the following cycle. `o_addr_err` is therefore high for exactly one cycle per offending request.
- R9: At the default widths (32-bit virtual, 36-bit physical), a kernel request for 0xBFC0_0000 yields `o_paddr`=0x0_1FC0_0000 with `o_cached`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Request strobe |
| i_vaddr | input | VA_W | Virtual address |
| i_user | input | 1 | 1 = user privilege, 0 = kernel |
| i_xlat_ready | input | 1 | External translator is set up and can accept requests |
| o_valid | output | 1 | Accepted request, result valid |
| o_paddr | output | PA_W | Bus address (direct segments) or passed-through virtual address (mapped segments) |
| o_cached | output | 1 | Access may be cached |
| o_need_mmu | output | 1 | Translation required |
| o_addr_err | output | 1 | Address error for the previous request |

## Verification
The main instance is built with an 8-bit virtual address and a 12-bit bus address. At that size, every address can be swept against both privilege modes and both translator states, back to back. This covers every segment boundary, the strip of the select bits, and every mix of the error causes. A second instance at the default 32/36-bit widths checks the boot-vector translation and one address from each segment at full scale.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
   // number of top address bits that select a segment
   localparam int SEL_W = 3;

   typedef enum logic [1:0] {
      SEG_USER     = 2'd0,
      SEG_DIRECT_C = 2'd1,
      SEG_DIRECT_U = 2'd2,
      SEG_KMAPPED  = 2'd3
   } seg_e;

   typedef struct packed {
      logic ok;
      logic err;
      logic need_mmu;
      logic cached;
   } seg_flags_t;
endpackage

// File: rtl/seg_classify.sv
module seg_classify
   import seg_dec_pkg::*;
(
   input  logic [SEL_W-1:0] i_sel,
   output seg_e             o_seg,
   output logic             o_mapped
);
   always_comb begin
      unique casez (i_sel)
         3'b0??:  o_seg = SEG_USER;
         3'b100:  o_seg = SEG_DIRECT_C;
         3'b101:  o_seg = SEG_DIRECT_U;
         default: o_seg = SEG_KMAPPED;
      endcase
      o_mapped = (o_seg == SEG_USER) || (o_seg == SEG_KMAPPED);
   end
endmodule

// File: rtl/seg_window.sv
module seg_window
   import seg_dec_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input  logic [VA_W-1:0] i_vaddr,
   input  logic            i_mapped,
   output logic [PA_W-1:0] o_paddr
);
   localparam int OFF_W  = VA_W - SEL_W;
   localparam int VA_PAD = PA_W - VA_W;

   logic [PA_W-1:0] pass_addr;
   logic [PA_W-1:0] direct_addr;

   generate
      if (VA_PAD == 0) begin : g_same_width
         assign pass_addr = i_vaddr;
      end else begin : g_wide_bus
         assign pass_addr = {{VA_PAD{1'b0}}, i_vaddr};
      end
   endgenerate

   // window offset: select bits forced to zero, upper bus bits zero
   assign direct_addr = {{(PA_W-OFF_W){1'b0}}, i_vaddr[OFF_W-1:0]};

   assign o_paddr = i_mapped ? pass_addr : direct_addr;
endmodule

// File: rtl/seg_permit.sv
module seg_permit
   import seg_dec_pkg::*;
(
   input  logic       i_valid,
   input  seg_e       i_seg,
   input  logic       i_mapped,
   input  logic       i_user,
   input  logic       i_xlat_ready,
   output seg_flags_t o_flags
);
   logic priv_fault;
   logic xlat_fault;
   logic fault;

   always_comb begin
      priv_fault = i_user && (i_seg != SEG_USER);
      xlat_fault = i_mapped && !i_xlat_ready;
      fault      = priv_fault || xlat_fault;

      o_flags.err      = i_valid && fault;
      o_flags.ok       = i_valid && !fault;
      o_flags.need_mmu = i_valid && !fault && i_mapped;
      o_flags.cached   = i_valid && !fault && (i_seg == SEG_DIRECT_C);
   end
endmodule

// File: rtl/seg_addr_decode.sv
module seg_addr_decode
   import seg_dec_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            i_valid,
   input  logic [VA_W-1:0] i_vaddr,
   input  logic            i_user,
   input  logic            i_xlat_ready,
   output logic            o_valid,
   output logic [PA_W-1:0] o_paddr,
   output logic            o_cached,
   output logic            o_need_mmu,
   output logic            o_addr_err
);
   generate
      if (VA_W < SEL_W + 1) begin : g_bad_va
         $error("seg_addr_decode: VA_W must exceed the select width");
      end
      if (PA_W < VA_W) begin : g_bad_pa
         $error("seg_addr_decode: PA_W must be at least VA_W");
      end
   endgenerate

   seg_e            seg;
   logic            mapped;
   logic [PA_W-1:0] comb_paddr;
   seg_flags_t      flags;

   seg_classify u_classify (
      .i_sel    (i_vaddr[VA_W-1 -: SEL_W]),
      .o_seg    (seg),
      .o_mapped (mapped)
   );

   seg_window #(.VA_W(VA_W), .PA_W(PA_W)) u_window (
      .i_vaddr  (i_vaddr),
      .i_mapped (mapped),
      .o_paddr  (comb_paddr)
   );

   seg_permit u_permit (
      .i_valid      (i_valid),
      .i_seg        (seg),
      .i_mapped     (mapped),
      .i_user       (i_user),
      .i_xlat_ready (i_xlat_ready),
      .o_flags      (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid    <= 1'b0;
         o_paddr    <= '0;
         o_cached   <= 1'b0;
         o_need_mmu <= 1'b0;
         o_addr_err <= 1'b0;
      end else begin
         o_valid    <= flags.ok;
         o_paddr    <= flags.ok ? comb_paddr : '0;
         o_cached   <= flags.cached;
         o_need_mmu <= flags.need_mmu;
         o_addr_err <= flags.err;
      end
   end
endmodule

// File: rtl/seg_addr_decode_chk.sv
module seg_addr_decode_chk
   import seg_dec_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            i_valid,
   input logic [VA_W-1:0] i_vaddr,
   input logic            i_user,
   input logic            i_xlat_ready,
   input logic            o_valid,
   input logic [PA_W-1:0] o_paddr,
   input logic            o_cached,
   input logic            o_need_mmu,
   input logic            o_addr_err
);
   localparam int OFF_W = VA_W - SEL_W;

   logic [SEL_W-1:0] sel;
   assign sel = i_vaddr[VA_W-1 -: SEL_W];

   // R2: cached direct window
   p_direct_cached_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_valid && !i_user && sel == 3'b100) |->
         (o_valid && o_cached && !o_need_mmu && !o_addr_err &&
          o_paddr == PA_W'($past(i_vaddr[OFF_W-1:0]))));

   // R3: uncached direct window
   p_direct_uncached_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_valid && !i_user && sel == 3'b101) |->
         (o_valid && !o_cached && !o_need_mmu && !o_addr_err &&
          o_paddr == PA_W'($past(i_vaddr[OFF_W-1:0]))));

   // R5: upper mapped segment in kernel mode
   p_kmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_valid && !i_user && i_xlat_ready && sel[2:1] == 2'b11) |->
         (o_valid && o_need_mmu && !o_cached && o_paddr == PA_W'($past(i_vaddr))));

   // R6: user access to upper half traps
   p_user_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_valid && i_user && sel[2]) |->
         (o_addr_err && !o_valid && !o_need_mmu && o_paddr == '0));

   // R7: mapped access with translator not ready traps
   p_xlat_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && i_valid && !i_xlat_ready && (!sel[2] || sel[2:1] == 2'b11)) |->
         (o_addr_err && !o_valid));

   // R8: idle cycle produces no result
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !i_valid) |-> (!o_valid && !o_addr_err && !o_need_mmu && !o_cached));

   // R8: a result is either accepted or an error, never both
   p_err_excludes_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({o_valid, o_addr_err}) <= 1);
endmodule

bind seg_addr_decode seg_addr_decode_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .i_valid      (i_valid),
   .i_vaddr      (i_vaddr),
   .i_user       (i_user),
   .i_xlat_ready (i_xlat_ready),
   .o_valid      (o_valid),
   .o_paddr      (o_paddr),
   .o_cached     (o_cached),
   .o_need_mmu   (o_need_mmu),
   .o_addr_err   (o_addr_err)
);

// File: tb/tb_seg_addr_decode.sv
`timescale 1ns/1ps
module tb_seg_addr_decode;
   localparam int SVA = 8;
   localparam int SPA = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // small instance
   logic           s_valid = 1'b0, s_user = 1'b0, s_rdy = 1'b0;
   logic [SVA-1:0] s_va = '0;
   logic           s_ov, s_c, s_m, s_e;
   logic [SPA-1:0] s_pa;

   seg_addr_decode #(.VA_W(SVA), .PA_W(SPA)) dut (
      .clk(clk), .rst_n(rst_n), .i_valid(s_valid), .i_vaddr(s_va),
      .i_user(s_user), .i_xlat_ready(s_rdy), .o_valid(s_ov), .o_paddr(s_pa),
      .o_cached(s_c), .o_need_mmu(s_m), .o_addr_err(s_e));

   // default-width instance
   logic        f_valid = 1'b0, f_user = 1'b0, f_rdy = 1'b0;
   logic [31:0] f_va = '0;
   logic        f_ov, f_c, f_m, f_e;
   logic [35:0] f_pa;

   seg_addr_decode dut_full (
      .clk(clk), .rst_n(rst_n), .i_valid(f_valid), .i_vaddr(f_va),
      .i_user(f_user), .i_xlat_ready(f_rdy), .o_valid(f_ov), .o_paddr(f_pa),
      .o_cached(f_c), .o_need_mmu(f_m), .o_addr_err(f_e));

   // expected {valid, err, mmu, cached, paddr[35:0]}
   function automatic logic [39:0] model(input logic [31:0] va, input int vw,
                                         input logic v, input logic u, input logic r);
      logic [2:0]  top;
      logic        mapped, err, ok;
      logic [35:0] pa;
      top    = 3'((va >> (vw - 3)) & 32'd7);
      mapped = !top[2] || top[2:1] == 2'b11;
      err    = v && ((u && top[2]) || (mapped && !r));
      ok     = v && !err;
      if (!ok)        pa = '0;
      else if (mapped) pa = 36'(va);
      else            pa = 36'(va & ((32'd1 << (vw - 3)) - 32'd1));
      return {ok, err, ok && mapped, ok && top == 3'b100, pa};
   endfunction

   function automatic string tag_of(input logic [31:0] va, input int vw,
                                    input logic v, input logic u, input logic r);
      logic [2:0] top;
      top = 3'((va >> (vw - 3)) & 32'd7);
      if (!v)                                   return "R8";
      if (u && top[2])                          return "R6";
      if ((!top[2] || top[2:1] == 2'b11) && !r) return "R7";
      if (!top[2])                              return "R4";
      if (top == 3'b100)                        return "R2";
      if (top == 3'b101)                        return "R3";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // drive one request on the small instance; check previous pending result first
   logic [39:0] pend_exp;
   string       pend_tag;
   logic        pend = 1'b0;

   task automatic small_step(input logic v, input logic [SVA-1:0] va, input logic u, input logic r);
      @(negedge clk);
      if (pend) check(pend_tag, {s_ov, s_e, s_m, s_c, 24'b0, s_pa}, pend_exp);
      s_valid = v; s_va = va; s_user = u; s_rdy = r;
      pend_exp = model(32'(va), SVA, v, u, r);
      pend_tag = tag_of(32'(va), SVA, v, u, r);
      pend = 1'b1;
   endtask

   task automatic full_req(input logic [31:0] va, input logic u, input logic r,
                           input string req, input logic [39:0] exp);
      @(negedge clk);
      f_valid = 1'b1; f_va = va; f_user = u; f_rdy = r;
      @(negedge clk);
      f_valid = 1'b0;
      check(req, {f_ov, f_e, f_m, f_c, f_pa}, exp);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", {s_ov, s_e, s_m, s_c, 24'b0, s_pa}, '0);
      check("R1", {f_ov, f_e, f_m, f_c, f_pa}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {s_ov, s_e, s_m, s_c, 24'b0, s_pa}, '0);

      // exhaustive back-to-back sweep: R2..R8
      for (int m = 0; m < 4; m++) begin
         for (int a = 0; a < (1 << SVA); a++) begin
            small_step(1'b1, SVA'(a), m[0], m[1]);
         end
      end
      // R8: idle gaps and isolated errors
      small_step(1'b0, 8'hFF, 1'b1, 1'b0);
      small_step(1'b1, 8'h80, 1'b1, 1'b1);
      small_step(1'b0, 8'h80, 1'b1, 1'b1);
      small_step(1'b1, 8'h10, 1'b0, 1'b0);
      small_step(1'b1, 8'h10, 1'b0, 1'b1);
      small_step(1'b0, 8'h00, 1'b0, 1'b1);
      small_step(1'b0, 8'h00, 1'b0, 1'b1);

      // default widths
      full_req(32'hBFC0_0000, 1'b0, 1'b1, "R9", {1'b1, 1'b0, 1'b0, 1'b0, 36'h0_1FC0_0000});
      full_req(32'h8000_1234, 1'b0, 1'b0, "R2", {1'b1, 1'b0, 1'b0, 1'b1, 36'h0_0000_1234});
      full_req(32'h0040_0000, 1'b1, 1'b1, "R4", {1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0040_0000});
      full_req(32'hC000_0008, 1'b0, 1'b1, "R5", {1'b1, 1'b0, 1'b1, 1'b0, 36'h0_C000_0008});
      full_req(32'h8000_0000, 1'b1, 1'b1, "R6", {1'b0, 1'b1, 1'b0, 1'b0, 36'h0});
      full_req(32'h7FFF_FFFC, 1'b0, 1'b0, "R7", {1'b0, 1'b1, 1'b0, 1'b0, 36'h0});
      @(negedge clk);
      check("R8", {f_ov, f_e, f_m, f_c, f_pa}, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule